// File: doc/BRIEF.md
# Video timing word conditioner

This block sits in front of a serializer and conditions each parallel video word before it goes out. On every rising edge of the parallel clock it registers a 10-bit word. When the upper eight bits of the word are all zeros or all ones, it treats the word as a reserved timing-reference value and overwrites the two least significant bits to match. A source that drives only the upper eight bits can therefore produce the same legal 10-bit reserved codes as a full 10-bit source.

A pair of one-cycle flags reports whether the registered word was recognised as the zeros-type or the ones-type reserved value. The bypass input turns off both detection and forcing. Arbitrary parallel data that is not video then passes through untouched, with no flags raised. All outputs are registered and appear one parallel-clock cycle after their input.

Top module: `tvc_conditioner`

## Requirements
- R1: While `rst` is high at a rising clock edge, `word_out` becomes 000h and both `hit_zero` and `hit_ones` become 0.
- R2: Every output reflects the inputs sampled at the previous rising clock edge, which is exactly one cycle of latency, both with and without bypass.
- R3: With `bypass` low and input bits 9..2 all 0, `word_out` bits 1..0 become 00 and `hit_zero` is 1 for that output cycle.
- R4: With `bypass` low and input bits 9..2 all 1, `word_out` bits 1..0 become 11 and `hit_ones` is 1 for that output cycle.
- R5: With `bypass` low and input bits 9..2 neither all 0 nor all 1, `word_out` equals the input word and both flags are 0.
- R6: With `bypass` high, `word_out` equals the input word unchanged, including for reserved words such as 001h and 3FEh, and both flags are 0.
- R7: `word_out` bits 9..2 always equal input bits 9..2 of the previous cycle.
- R8: `hit_zero` and `hit_ones` are never high together. Each stays high for one cycle only, unless the next word is also reserved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | 10 | Parallel video word |
| bypass | input | 1 | High disables reserved-word detection and forcing |
| word_out | output | 10 | Registered conditioned word |
| hit_zero | output | 1 | Registered: the word was an all-zeros reserved word |
| hit_ones | output | 1 | Registered: the word was an all-ones reserved word |

## Verification
On every cycle after reset, the assertions check several properties. The upper bits pass through with one cycle of delay. Forcing to 00 or 11 happens when the head bits are uniform. Bypass yields an exact copy with quiet flags, and the two flags never overlap. The reset value, the exact words sent for each of the eight 10-bit reserved codes, the near-miss codes 004h and 3FBh, and a mid-stream reset can only be shown by the bench's scenarios. The bench compares each registered result against a scoreboard model.

// File: rtl/tvc_pkg.sv
package tvc_pkg;
  typedef enum logic [1:0] {
    MATCH_NONE = 2'b00,
    MATCH_ZERO = 2'b01,
    MATCH_ONES = 2'b10
  } match_e;
endpackage

// File: rtl/tvc_detect.sv
module tvc_detect
  import tvc_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int TAG_W  = 2
) (
  input  logic [WORD_W-1:0] word,
  input  logic              off,
  output match_e            kind
);
  localparam int HEAD_W = WORD_W - TAG_W;

  logic [HEAD_W-1:0] head;
  assign head = word[WORD_W-1:TAG_W];

  always_comb begin
    if (off)                     kind = MATCH_NONE;
    else if (head == '0)         kind = MATCH_ZERO;
    else if (head == {HEAD_W{1'b1}}) kind = MATCH_ONES;
    else                         kind = MATCH_NONE;
  end
endmodule

// File: rtl/tvc_force.sv
module tvc_force
  import tvc_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int TAG_W  = 2
) (
  input  logic [WORD_W-1:0] word,
  input  match_e            kind,
  output logic [WORD_W-1:0] fixed
);
  always_comb begin
    fixed = word;
    case (kind)
      MATCH_ZERO: fixed[TAG_W-1:0] = '0;
      MATCH_ONES: fixed[TAG_W-1:0] = '1;
      default:    fixed = word;
    endcase
  end
endmodule

// File: rtl/tvc_outreg.sv
module tvc_outreg
  import tvc_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] fixed,
  input  match_e            kind,
  input  logic [WORD_W-1:0] raw,
  input  logic              off,
  output logic [WORD_W-1:0] q_word,
  output logic              q_zero,
  output logic              q_ones
);
  localparam int HEAD_W = WORD_W - TAG_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_word <= '0;
      q_zero <= 1'b0;
      q_ones <= 1'b0;
    end else begin
      q_word <= fixed;
      q_zero <= (kind == MATCH_ZERO);
      q_ones <= (kind == MATCH_ONES);
    end
  end

  assert_head_delay_R7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> q_word[WORD_W-1:TAG_W] == $past(raw[WORD_W-1:TAG_W]));

  assert_zero_force_R3: assert property (@(posedge clk) disable iff (rst)
    (!rst && !off && raw[WORD_W-1:TAG_W] == '0) |=> (q_word[TAG_W-1:0] == '0 && q_zero));

  assert_ones_force_R4: assert property (@(posedge clk) disable iff (rst)
    (!rst && !off && raw[WORD_W-1:TAG_W] == {HEAD_W{1'b1}})
      |=> (q_word[TAG_W-1:0] == {TAG_W{1'b1}} && q_ones));

  assert_bypass_copy_R6: assert property (@(posedge clk) disable iff (rst)
    (!rst && off) |=> (q_word == $past(raw) && !q_zero && !q_ones));

  assert_plain_copy_R5: assert property (@(posedge clk) disable iff (rst)
    (!rst && raw[WORD_W-1:TAG_W] != '0 && raw[WORD_W-1:TAG_W] != {HEAD_W{1'b1}})
      |=> (q_word == $past(raw) && !q_zero && !q_ones));

  assert_flag_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(q_zero && q_ones));
endmodule

// File: rtl/tvc_conditioner.sv
module tvc_conditioner
  import tvc_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_in,
  input  logic              bypass,
  output logic [WORD_W-1:0] word_out,
  output logic              hit_zero,
  output logic              hit_ones
);
  match_e            kind;
  logic [WORD_W-1:0] fixed;

  tvc_detect #(.WORD_W(WORD_W), .TAG_W(TAG_W)) u_detect (
    .word(word_in), .off(bypass), .kind(kind)
  );

  tvc_force #(.WORD_W(WORD_W), .TAG_W(TAG_W)) u_force (
    .word(word_in), .kind(kind), .fixed(fixed)
  );

  tvc_outreg #(.WORD_W(WORD_W), .TAG_W(TAG_W)) u_outreg (
    .clk(clk), .rst(rst), .fixed(fixed), .kind(kind), .raw(word_in),
    .off(bypass), .q_word(word_out), .q_zero(hit_zero), .q_ones(hit_ones)
  );
endmodule

// File: tb/sim_tvc_conditioner.sv
module sim_tvc_conditioner;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [9:0] w;
    logic       z;
    logic       o;
    logic [9:0] src;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] word_in = '0;
  logic       bypass = 1'b0;
  logic [9:0] word_out;
  logic       hit_zero, hit_ones;

  int errors = 0;
  int checks = 0;
  item_t sb[$];
  bit done = 0;

  tvc_conditioner u0 (
    .clk(clk), .rst(rst), .word_in(word_in), .bypass(bypass),
    .word_out(word_out), .hit_zero(hit_zero), .hit_ones(hit_ones)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%03h expected=%03h", req, what, act, exp);
    end
  endtask

  // Driver: applies a word at the falling edge and records the expected result.
  task automatic drive(input logic [9:0] w, input logic off);
    item_t it;
    @(negedge clk);
    word_in = w;
    bypass  = off;
    it.src = w;
    it.w = w; it.z = 1'b0; it.o = 1'b0;
    if (off) it.req = "R6";
    else if (w[9:2] == 8'h00) begin it.w[1:0] = 2'b00; it.z = 1'b1; it.req = "R3"; end
    else if (w[9:2] == 8'hFF) begin it.w[1:0] = 2'b11; it.o = 1'b1; it.req = "R4"; end
    else it.req = "R5";
    sb.push_back(it);
  endtask

  // Monitor: one cycle after capture, compare against the scoreboard head (R2).
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(word_out == it.w, it.req, "word_out (R2 latency)", word_out, it.w);
      check(hit_zero == it.z, it.req, "hit_zero", {9'd0, hit_zero}, {9'd0, it.z});
      check(hit_ones == it.o, it.req, "hit_ones", {9'd0, hit_ones}, {9'd0, it.o});
      check(word_out[9:2] == it.src[9:2], "R7", "head bits", word_out, it.src);
      check(!(hit_zero && hit_ones), "R8", "flag overlap", {8'd0, hit_zero, hit_ones}, 10'd0);
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [9:0] lf;
    word_in = 10'h3FF;
    repeat (3) @(negedge clk);
    // R1: reset state with a reserved word at the input
    check(word_out == 10'h000, "R1", "reset word_out", word_out, 10'h000);
    check(!hit_zero && !hit_ones, "R1", "reset flags", {8'd0, hit_zero, hit_ones}, 10'd0);
    rst = 1'b0;

    // R3 / R4: every 10-bit reserved code
    for (int i = 0; i < 4; i++) drive(10'(i), 1'b0);
    for (int i = 0; i < 4; i++) drive(10'h3FC + 10'(i), 1'b0);
    // R8: flag must drop after a single reserved word
    drive(10'h3FD, 1'b0);
    drive(10'h155, 1'b0);
    drive(10'h002, 1'b0);
    drive(10'h2AA, 1'b0);
    // R5: near misses
    drive(10'h004, 1'b0);
    drive(10'h3FB, 1'b0);
    drive(10'h201, 1'b0);
    drive(10'h1FE, 1'b0);
    // R6: bypass passes reserved words unchanged
    drive(10'h001, 1'b1);
    drive(10'h3FE, 1'b1);
    drive(10'h002, 1'b1);
    drive(10'h2AA, 1'b1);
    drive(10'h003, 1'b0);
    // mixed pseudo-random stream
    lf = 10'h2D3;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[8:0], lf[9] ^ lf[6]};
      drive((i % 5 == 0) ? {lf[9] ? 8'hFF : 8'h00, lf[1:0]} : lf, (i % 7 == 3));
    end

    // R1: mid-stream reset
    @(negedge clk);
    rst = 1'b1;
    word_in = 10'h3FF;
    bypass = 1'b0;
    @(negedge clk);
    check(word_out == 10'h000, "R1", "mid reset word_out", word_out, 10'h000);
    check(!hit_zero && !hit_ones, "R1", "mid reset flags", {8'd0, hit_zero, hit_ones}, 10'd0);
    rst = 1'b0;
    drive(10'h3FE, 1'b0);
    repeat (3) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule